// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block maps the program ROM and the character ROM of a cartridge for an 8-bit console. Any CPU write to the upper 32 KiB window loads a configuration latch. Most of the latch comes from the write address, and only two bits come from the data byte. The latch selects:

- one of four 512 KiB program chips;
- a program page, shown either as one 32 KiB bank or as a 16 KiB bank repeated in both halves of the window;
- a 6-bit character bank covering the whole 8 KiB pattern space;
- the nametable mirroring.

Chip slot 2 is unpopulated, so reads from it are flagged as open bus. The block also holds four 4-bit scratch registers in the expansion area. A parameter gives a reduced build with a single 256 KiB program ROM.

The ROM arrays, the nametable RAM and the CPU are outside the block. The block only produces addresses, an open-bus mask, scratch read data and the mirroring control.

Top module: `addr_latch_mapper`

## Requirements
- R1: A write (cpu_we high at a clock edge) with cpu_addr[15]=1 loads the latch, and the new value shows on the outputs after that edge. Writes below 0x8000 leave mirror_horiz, chr_addr and prg_addr unchanged.
- R2: mirror_horiz takes cpu_addr[13] of the last latch write (0 = vertical, 1 = horizontal).
- R3: The character bank is {cpu_addr[3:0], cpu_wdata[1:0]} of the last latch write, and chr_addr = bank*8192 + ppu_addr.
- R4: In mode 0 (latched cpu_addr[5]=0), the in-chip offset is (page>>1)*32768 + cpu_addr[14:0], where page is the latched cpu_addr[10:6]. Bit 0 of page is ignored.
- R5: In mode 1, the in-chip offset is page*16384 + cpu_addr[13:0], so the same 16 KiB bank appears at 0x8000 and at 0xC000.
- R6: In the full build (SINGLE_CHIP=0), prg_addr = chip*524288 + offset in both modes, where chip is the latched cpu_addr[12:11].
- R7: For cpu_addr >= 0x8000, cpu_rd_open is 8'hFF when the latched chip is 2 in the full build, and 8'h00 in every other case.
- R8: A write to 0x4020–0x5FFF stores cpu_wdata[3:0] in scratch register cpu_addr[1:0]. While cpu_addr is in that range, cpu_rdata is {4'h0, register} and cpu_rd_open is 8'hF0. Outside that range, cpu_rdata is 0.
- R9: For cpu_addr below 0x4020, cpu_rd_open is 8'hFF.
- R10: Reset gives the state of a write of 0x00 to 0x8000: vertical mirroring, chip 0, page 0, mode 0 and character bank 0. Reset also clears the scratch registers.
- R11: With SINGLE_CHIP=1, the chip bits are ignored and prg_addr = offset mod 262144. Upper window reads are never flagged open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Scratch register read data |
| cpu_rd_open | output | 8 | Per-bit mask of bits the cartridge leaves floating |
| prg_addr | output | 21 | Program ROM byte address |
| ppu_addr | input | 13 | Video pattern-space address |
| chr_addr | output | 19 | Character ROM byte address |
| mirror_horiz | output | 1 | Nametable mirroring (1 = horizontal) |

## Verification
The assertions assume the following about the inputs:
- cpu_we is a single-cycle strobe sampled at the clock edge.
- cpu_addr and cpu_wdata are known and held steady across that edge.
- rst_n is released synchronously.

The bench changes all inputs only at the falling edge, so every write is one clean edge. Its addresses are drawn from four classes: the latch window, the scratch window, the space below the scratch window, and plain reads. This keeps the stimulus inside those assumptions while still reaching all three read-flag outcomes.

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper #(
  parameter bit SINGLE_CHIP = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  output logic [7:0]  cpu_rdata,
  output logic [7:0]  cpu_rd_open,
  output logic [20:0] prg_addr,
  input  logic [12:0] ppu_addr,
  output logic [18:0] chr_addr,
  output logic        mirror_horiz
);
  localparam int PAGE_W = 5;
  localparam int CHR_W  = 6;
  localparam int NREGS  = 4;
  localparam logic [15:0] EXP_LO = 16'h4020;
  localparam logic [15:0] EXP_HI = 16'h5FFF;

  logic              mir_q, mode_q;
  logic [1:0]        chip_q;
  logic [PAGE_W-1:0] page_q;
  logic [CHR_W-1:0]  chr_q;
  logic [3:0]        ram_q [NREGS];
  logic [18:0]       bank_off;
  logic              cfg_wr, in_exp, chip_absent;
  logic              unused_bits;

  assign cfg_wr = cpu_we && cpu_addr[15];
  assign in_exp = (cpu_addr >= EXP_LO) && (cpu_addr <= EXP_HI);
  assign unused_bits = ^{cpu_wdata[7:4], cpu_addr[4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir_q  <= 1'b0;
      chip_q <= 2'd0;
      page_q <= '0;
      mode_q <= 1'b0;
      chr_q  <= '0;
    end else if (cfg_wr) begin
      mir_q  <= cpu_addr[13];
      chip_q <= cpu_addr[12:11];
      page_q <= cpu_addr[10:6];
      mode_q <= cpu_addr[5];
      chr_q  <= {cpu_addr[3:0], cpu_wdata[1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) ram_q[i] <= 4'h0;
    end else if (cpu_we && in_exp) begin
      ram_q[cpu_addr[1:0]] <= cpu_wdata[3:0];
    end
  end

  assign bank_off = mode_q ? {page_q, cpu_addr[13:0]} : {page_q[4:1], cpu_addr[14:0]};

  generate
    if (SINGLE_CHIP) begin : g_single
      assign prg_addr    = {3'b000, bank_off[17:0]};
      assign chip_absent = 1'b0;
    end else begin : g_multi
      assign prg_addr    = {chip_q, bank_off};
      assign chip_absent = (chip_q == 2'd2);
    end
  endgenerate

  assign cpu_rd_open  = cpu_addr[15] ? (chip_absent ? 8'hFF : 8'h00)
                      : in_exp ? 8'hF0 : 8'hFF;
  assign cpu_rdata    = in_exp ? {4'h0, ram_q[cpu_addr[1:0]]} : 8'h00;
  assign chr_addr     = {chr_q, ppu_addr};
  assign mirror_horiz = mir_q;

  p_mirror_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> mirror_horiz == $past(cpu_addr[13]));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we || !cpu_addr[15]) |=> ($stable(mirror_horiz) && $stable(chr_addr[18:13])));

  p_chr_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> chr_addr[18:13] == {$past(cpu_addr[3:0]), $past(cpu_wdata[1:0])});

  p_absent_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cpu_addr[12:11] == 2'd2 && !SINGLE_CHIP) |=>
      (!cpu_addr[15] || cpu_rd_open == 8'hFF));

  p_scratch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && in_exp) |=>
      ((!in_exp || cpu_addr[1:0] != $past(cpu_addr[1:0])) ||
       cpu_rdata == {4'h0, $past(cpu_wdata[3:0])}));
endmodule

// File: tb/addr_latch_mapper_bench.sv
`timescale 1ns/1ps
module addr_latch_mapper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0] cpu_wdata = 8'h0;
  logic cpu_we = 1'b0;
  logic [12:0] ppu_addr = 13'h0;
  logic [7:0] rd_f, op_f, rd_s, op_s;
  logic [20:0] pa_f, pa_s;
  logic [18:0] ca_f, ca_s;
  logic mh_f, mh_s;
  int n_cmp = 0, n_bad = 0;
  int m_mir, m_chip, m_page, m_mode, m_chr;
  int m_ram [4];

  always #2 clk = ~clk;

  addr_latch_mapper #(.SINGLE_CHIP(1'b0)) u_addr_latch_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(rd_f), .cpu_rd_open(op_f), .prg_addr(pa_f), .ppu_addr(ppu_addr),
    .chr_addr(ca_f), .mirror_horiz(mh_f));

  addr_latch_mapper #(.SINGLE_CHIP(1'b1)) u_addr_latch_mapper_small (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(rd_s), .cpu_rd_open(op_s), .prg_addr(pa_s), .ppu_addr(ppu_addr),
    .chr_addr(ca_s), .mirror_horiz(mh_s));

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (addr %h)", req, act, exp, cpu_addr);
    end
  endtask

  task automatic model_reset();
    m_mir = 0; m_chip = 0; m_page = 0; m_mode = 0; m_chr = 0;
    for (int i = 0; i < 4; i++) m_ram[i] = 0;
  endtask

  function automatic longint offs(input int a, input int pg, input int md);
    return md ? longint'(pg) * 16384 + (a % 16384) : longint'(pg / 2) * 32768 + (a % 32768);
  endfunction

  task automatic compare_all();
    int a = int'(cpu_addr);
    bit exp_rng = (a >= 'h4020) && (a <= 'h5FFF);
    chk("R2 mirror", mh_f, m_mir);
    chk("R3 chr_addr", ca_f, longint'(m_chr) * 8192 + ppu_addr);
    chk(m_mode ? "R5/R6 prg_addr" : "R4/R6 prg_addr", pa_f,
        longint'(m_chip) * 524288 + offs(a, m_page, m_mode));
    chk("R11 prg_addr small", pa_s, offs(a, m_page, m_mode) % 262144);
    if (a >= 'h8000) begin
      chk("R7 open full", op_f, (m_chip == 2) ? 'hFF : 'h00);
      chk("R11 open small", op_s, 'h00);
    end else if (exp_rng) begin
      chk("R8 open", op_f, 'hF0);
    end else begin
      chk("R9 open", op_f, 'hFF);
    end
    chk("R8 rdata", rd_f, exp_rng ? m_ram[a % 4] : 0);
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic we);
    cpu_addr = a; cpu_wdata = d; cpu_we = we; ppu_addr = 13'($urandom);
    #1 compare_all();
    @(posedge clk);
    if (we && a[15]) begin
      m_mir = a[13]; m_chip = a[12:11]; m_page = a[10:6]; m_mode = a[5];
      m_chr = {a[3:0], d[1:0]};
    end
    if (we && a >= 16'h4020 && a <= 16'h5FFF) m_ram[a[1:0]] = d[3:0];
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset mirror", mh_f, 0);
    chk("R10 reset chr", ca_f[18:13], 0);
    chk("R10 reset prg", pa_f, {6'h0, cpu_addr[14:0]});
    rst_n = 1'b1;
    @(negedge clk);
    step(16'h8000 | (1 << 13) | (3 << 11) | (21 << 6) | (1 << 5) | 4'hA, 8'h03, 1'b1);
    step(16'hC123, 8'h00, 1'b0);
    step(16'h8123, 8'h00, 1'b0);
    step(16'h8000 | (2 << 11) | (7 << 6) | 4'h5, 8'h02, 1'b1);
    step(16'hFFFF, 8'h00, 1'b0);
    step(16'h1234, 8'hFF, 1'b1);
    step(16'h8000, 8'h00, 1'b0);
    step(16'h4021, 8'hA7, 1'b1);
    step(16'h5FFD, 8'h00, 1'b0);
    step(16'h401F, 8'h00, 1'b0);
    step(16'h8000 | (1 << 11) | (31 << 6), 8'h01, 1'b1);
    step(16'hE000, 8'h00, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      int c = int'($urandom % 4);
      logic [15:0] a;
      case (c)
        0: a = 16'h8000 | 16'($urandom);
        1: a = 16'h4020 + 16'($urandom % 16'h1FE0);
        2: a = 16'($urandom % 16'h4020);
        default: a = 16'($urandom);
      endcase
      step(a, 8'($urandom), (c != 3));
      if (i == 1500) begin
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        #1 chk("R10 mid reset mirror", mh_f, 0);
        rst_n = 1'b1;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule